// File: doc/BRIEF.md
# Grouped Interrupt Mask and Priority Controller

This block keeps the priority and mask configuration for sixteen fixed interrupt sources. It offers the result of a priority vote to the processor core. Software programs three priority registers and one mask register over a simple synchronous register bus. The first two priority registers are 16 bits wide and the third is 32 bits wide. All three are divided into 4-bit fields. The mask register has two addresses: one address sets bits and the other clears them.

A single priority field may govern a whole group of sources, such as both channels of a timer, the three clock sources or the four serial sources. Some sources are governed by several fields at once. A source takes part in arbitration only when every field that governs it is nonzero.

Each cycle, the block looks at the pending request lines. From the pending sources that are enabled, it reports the one with the highest priority. The report carries a valid flag, the fixed 12-bit vector code of that source and its 4-bit priority. All three appear combinationally in the same cycle.

Top module: `intc_grouped`

## Requirements
- R1: After reset, every register reads as zero, every source is disabled and irq_valid_o is 0.
- R2: Priority registers A (address 0x04) and B (address 0x08) store only wdata_i[15:0] and read back with bits 31:16 at zero. The fields of A are: bits 15:12 for source 0, bits 11:8 for source 1, bits 7:4 for sources 2 and 3, and bits 3:0 for sources 4, 5 and 6. The fields of B are: bits 15:12 for source 7, bits 11:8 for sources 8 and 9, and bits 7:4 for sources 10 to 13.
- R3: A write to the mask set address (0x20) ORs wdata_i into the mask, and no mask bit is cleared.
- R4: A write to the mask clear address (0x24) yields old mask AND NOT wdata_i, and no mask bit is set. A read from either address returns the mask.
- R5: Priority register X (address 0x10) stores all 32 bits. Bits 15:12 are the priority of source 15 and bits 11:8 are the priority of source 14.
- R6: A field that governs a group enables every member of the group at once, and every member takes that field's value as its priority.
- R7: Sources 14 and 15 are enabled only when their X field is nonzero and their mask bit is set: bit 8 for source 14 and bit 9 for source 15. All other sources need only their priority field to be nonzero.
- R8: Among the sources that are both pending and enabled, the one with the highest priority is reported. On equal priority, the lowest source index wins.
- R9: The vector codes of sources 0 to 15 are, in order: 0x400, 0x420, 0x440, 0x460, 0x480, 0x4A0, 0x4C0, 0x560, 0x580, 0x5A0, 0x4E0, 0x500, 0x520, 0x540, 0xB00 and 0xB80.
- R10: The unassigned fields have no effect on any source. These are B[3:0], X[31:16], X[7:0] and mask bits other than 8 and 9. Writes to unmapped addresses change nothing, and reads of unmapped addresses return zero.
- R11: rdata_o shows the register selected by addr_i one cycle later. A read in the same cycle as a write to that register returns the value from before the write.
- R12: irq_valid_o, irq_vector_o and irq_prio_o follow pend_i and the register state in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pend_i | input | 16 | Pending request per source |
| irq_valid_o | output | 1 | An enabled source is pending |
| irq_vector_o | output | 12 | Vector code of the winning source |
| irq_prio_o | output | 4 | Priority of the winning source |

## Verification
Two things can happen in the same cycle: a register write and the combinational arbitration that depends on that register. Likewise, a write and a read of the same address can coincide. The bench drives pend_i across a write to a priority field or mask bit. A behavioural model updates only at the clock edge, so it checks that the outputs switch exactly one edge after the write and that the read captured in the write cycle still shows the old value. Ties, group members and the sources governed by two fields are all compared against the model on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC   = 16;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 12;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int BANK_W = 2 * HALF_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_PRIO_A   = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_PRIO_B   = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_PRIO_X   = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_MASK_SET = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_MASK_CLR = 8'h24;

  // bank layout: {prio_x, prio_b, prio_a}; returns lsb of the governing field
  function automatic int src_field_pos(int s);
    case (s)
      0:                src_field_pos = 12;
      1:                src_field_pos = 8;
      2, 3:             src_field_pos = 4;
      4, 5, 6:          src_field_pos = 0;
      7:                src_field_pos = HALF_W + 12;
      8, 9:             src_field_pos = HALF_W + 8;
      10, 11, 12, 13:   src_field_pos = HALF_W + 4;
      14:               src_field_pos = 2 * HALF_W + 8;
      default:          src_field_pos = 2 * HALF_W + 12;
    endcase
  endfunction

  // mask bit that also gates the source, -1 when none
  function automatic int src_mask_bit(int s);
    case (s)
      14:      src_mask_bit = 8;
      15:      src_mask_bit = 9;
      default: src_mask_bit = -1;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] src_vec(int s);
    case (s)
      0:       src_vec = 12'h400;
      1:       src_vec = 12'h420;
      2:       src_vec = 12'h440;
      3:       src_vec = 12'h460;
      4:       src_vec = 12'h480;
      5:       src_vec = 12'h4A0;
      6:       src_vec = 12'h4C0;
      7:       src_vec = 12'h560;
      8:       src_vec = 12'h580;
      9:       src_vec = 12'h5A0;
      10:      src_vec = 12'h4E0;
      11:      src_vec = 12'h500;
      12:      src_vec = 12'h520;
      13:      src_vec = 12'h540;
      14:      src_vec = 12'hB00;
      default: src_vec = 12'hB80;
    endcase
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int HW = HALF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [HW-1:0] prio_a_o,
  output logic [HW-1:0] prio_b_o,
  output logic [DW-1:0] prio_x_o,
  output logic [DW-1:0] mask_o
);
  logic [HW-1:0] prio_a_q, prio_b_q;
  logic [DW-1:0] prio_x_q, mask_q, rd_mux, rdata_q;

  always_comb begin
    unique case (addr_i)
      ADR_PRIO_A:                 rd_mux = DW'(prio_a_q);
      ADR_PRIO_B:                 rd_mux = DW'(prio_b_q);
      ADR_PRIO_X:                 rd_mux = prio_x_q;
      ADR_MASK_SET, ADR_MASK_CLR: rd_mux = mask_q;
      default:                    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_a_q <= '0;
      prio_b_q <= '0;
      prio_x_q <= '0;
      mask_q   <= '0;
      rdata_q  <= '0;
    end else begin
      rdata_q <= rd_mux;  // pre-write value on a coinciding access
      if (we_i) begin
        unique case (addr_i)
          ADR_PRIO_A:   prio_a_q <= wdata_i[HW-1:0];
          ADR_PRIO_B:   prio_b_q <= wdata_i[HW-1:0];
          ADR_PRIO_X:   prio_x_q <= wdata_i;
          ADR_MASK_SET: mask_q   <= mask_q | wdata_i;
          ADR_MASK_CLR: mask_q   <= mask_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign prio_a_o = prio_a_q;
  assign prio_b_o = prio_b_q;
  assign prio_x_o = prio_x_q;
  assign mask_o   = mask_q;

  a_r3_set_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_MASK_SET) |=> (($past(mask_q) & ~mask_q) == '0));
  a_r4_clr_adds_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADR_MASK_CLR) |=> ((mask_q & ~$past(mask_q)) == '0));
  a_r10_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(prio_a_q) && $stable(prio_b_q) && $stable(prio_x_q) && $stable(mask_q)));
endmodule

// File: rtl/intc_enable.sv
module intc_enable
  import intc_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int PW = PRIO_W,
  parameter int HW = HALF_W,
  parameter int DW = DATA_W,
  localparam int BW = 2 * HW + DW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [HW-1:0]         prio_a_i,
  input  logic [HW-1:0]         prio_b_i,
  input  logic [DW-1:0]         prio_x_i,
  input  logic [DW-1:0]         mask_i,
  output logic [NS-1:0]         en_o,
  output logic [NS-1:0][PW-1:0] prio_o
);
  logic [BW-1:0] bank;
  logic          unused_bits;

  assign bank        = {prio_x_i, prio_b_i, prio_a_i};
  assign unused_bits = ^{bank, mask_i};

  for (genvar s = 0; s < NS; s++) begin : g_src
    localparam int POS  = src_field_pos(s);
    localparam int MBIT = src_mask_bit(s);
    localparam int REQ  = (MBIT >= 0) ? 2 : 1;
    logic [PW-1:0] fld;
    logic [1:0]    act_cnt;

    assign fld = bank[POS +: PW];

    if (MBIT >= 0) begin : g_masked
      assign act_cnt = 2'(fld != '0) + 2'(mask_i[MBIT]);
    end else begin : g_plain
      assign act_cnt = 2'(fld != '0);
    end

    // enabled when every governing field is active
    assign en_o[s]   = (act_cnt == 2'(REQ));
    assign prio_o[s] = fld;

    a_r7_enabled_has_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[s] |-> (prio_o[s] != '0));
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int PW = PRIO_W,
  localparam int IW = $clog2(NS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NS-1:0]         cand_i,
  input  logic [NS-1:0][PW-1:0] prio_i,
  output logic                  valid_o,
  output logic [IW-1:0]         idx_o,
  output logic [PW-1:0]         prio_o
);
  always_comb begin
    idx_o  = '0;
    prio_o = '0;
    // descending scan with >= lets the lowest index win a tie
    for (int i = NS - 1; i >= 0; i--) begin
      if (cand_i[i] && prio_i[i] != '0 && prio_i[i] >= prio_o) begin
        idx_o  = IW'(i);
        prio_o = prio_i[i];
      end
    end
  end

  assign valid_o = (prio_o != '0);

  a_r8_grant_is_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cand_i[idx_o] && prio_i[idx_o] == prio_o));
  a_r8_idle_without_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i == '0) |-> !valid_o);
endmodule

// File: rtl/intc_grouped.sv
module intc_grouped
  import intc_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int PW = PRIO_W,
  parameter int VW = VEC_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  localparam int HW = HALF_W,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NS-1:0] pend_i,
  output logic          irq_valid_o,
  output logic [VW-1:0] irq_vector_o,
  output logic [PW-1:0] irq_prio_o
);
  logic [HW-1:0]         prio_a, prio_b;
  logic [DW-1:0]         prio_x, mask;
  logic [NS-1:0]         src_en;
  logic [NS-1:0][PW-1:0] src_prio;
  logic [IW-1:0]         win_idx;
  logic                  win_valid;

  intc_regs #(.AW(AW), .DW(DW), .HW(HW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .prio_a_o(prio_a), .prio_b_o(prio_b), .prio_x_o(prio_x), .mask_o(mask)
  );

  intc_enable #(.NS(NS), .PW(PW), .HW(HW), .DW(DW)) u_enable (
    .clk_i, .rst_ni,
    .prio_a_i(prio_a), .prio_b_i(prio_b), .prio_x_i(prio_x), .mask_i(mask),
    .en_o(src_en), .prio_o(src_prio)
  );

  intc_arbiter #(.NS(NS), .PW(PW)) u_arb (
    .clk_i, .rst_ni,
    .cand_i(pend_i & src_en), .prio_i(src_prio),
    .valid_o(win_valid), .idx_o(win_idx), .prio_o(irq_prio_o)
  );

  assign irq_valid_o  = win_valid;
  assign irq_vector_o = win_valid ? VW'(src_vec(int'(win_idx))) : '0;

  a_r8_valid_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (pend_i != '0 && irq_prio_o != '0));
endmodule

// File: tb/intc_grouped_tb.sv
`timescale 1ns/100ps
module intc_grouped_tb;
  localparam logic [7:0] A_A = 8'h04, A_B = 8'h08, A_X = 8'h10, A_SET = 8'h20, A_CLR = 8'h24;

  logic        clk = 0, rst_n = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] pend = 0;
  logic        valid;
  logic [11:0] vector;
  logic [3:0]  prio;
  int          n_chk = 0, n_err = 0;

  // behavioural model state
  logic [15:0] m_a, m_b;
  logic [31:0] m_x, m_mask, m_rd;

  always #2.5 clk = ~clk;

  intc_grouped u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pend_i(pend), .irq_valid_o(valid),
    .irq_vector_o(vector), .irq_prio_o(prio)
  );

  function automatic logic [11:0] exp_vec(int s);
    logic [11:0] t[16] = '{12'h400, 12'h420, 12'h440, 12'h460, 12'h480, 12'h4A0, 12'h4C0,
                           12'h560, 12'h580, 12'h5A0, 12'h4E0, 12'h500, 12'h520, 12'h540,
                           12'hB00, 12'hB80};
    return t[s];
  endfunction

  function automatic int m_prio(int s);
    if (s == 0) return m_a[15:12];
    if (s == 1) return m_a[11:8];
    if (s <= 3) return m_a[7:4];
    if (s <= 6) return m_a[3:0];
    if (s == 7) return m_b[15:12];
    if (s <= 9) return m_b[11:8];
    if (s <= 13) return m_b[7:4];
    if (s == 14) return m_mask[8] ? int'(m_x[11:8]) : 0;
    return m_mask[9] ? int'(m_x[15:12]) : 0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == A_A) return {16'h0, m_a};
    if (a == A_B) return {16'h0, m_b};
    if (a == A_X) return m_x;
    if (a == A_SET || a == A_CLR) return m_mask;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= 0; m_b <= 0; m_x <= 0; m_mask <= 0; m_rd <= 0;
    end else begin
      m_rd <= m_read(addr);
      if (we) begin
        if (addr == A_A) m_a <= wdata[15:0];
        else if (addr == A_B) m_b <= wdata[15:0];
        else if (addr == A_X) m_x <= wdata;
        else if (addr == A_SET) m_mask <= m_mask | wdata;
        else if (addr == A_CLR) m_mask <= m_mask & ~wdata;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int best_p = 0, best_s = 0;
    for (int s = 0; s < 16; s++)
      if (pend[s] && m_prio(s) > best_p) begin best_p = m_prio(s); best_s = s; end
    check(valid == (best_p != 0), "R8 valid vs model", 32'(valid), 32'(best_p != 0));
    if (best_p != 0) begin
      check(prio == 4'(best_p), "R8 prio vs model", 32'(prio), 32'(best_p));
      check(vector == exp_vec(best_s), "R9 vector vs model", 32'(vector), 32'(exp_vec(best_s)));
    end
    check(rdata == m_rd, "R11 rdata vs model", rdata, m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    tick();
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    tick();
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic expect_irq(input logic v, input logic [11:0] vec, input logic [3:0] p, input string tag);
    #1;
    check(valid == v, tag, 32'(valid), 32'(v));
    if (v) begin
      check(vector == vec, tag, 32'(vector), 32'(vec));
      check(prio == p, tag, 32'(prio), 32'(p));
    end
  endtask

  initial begin
    #(5ns * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    rd(A_A, 0, "R1 prio A after reset");
    rd(A_X, 0, "R1 prio X after reset");
    rd(A_SET, 0, "R1 mask after reset");
    pend = 16'hFFFF;
    expect_irq(0, 0, 0, "R1 no source enabled");
    pend = 0;

    // R2 half-width register
    wr(A_A, 32'hABCD_1234);
    rd(A_A, 32'h0000_1234, "R2 prio A upper bits dropped");

    // R12 combinational response, R6 group member
    pend = 16'h0008;
    expect_irq(1, 12'h460, 4'd3, "R12 R6 timer group member");
    pend = 16'h000C;
    expect_irq(1, 12'h440, 4'd3, "R8 tie lowest index");
    pend = 16'h002C;
    expect_irq(1, 12'h4A0, 4'd4, "R6 clock group wins");
    pend = 16'h0003;
    expect_irq(1, 12'h420, 4'd2, "R8 higher priority wins");
    tick();

    // R3 / R4 mask set and clear
    wr(A_SET, 32'h0000_0300);
    wr(A_SET, 32'h0000_0001);
    rd(A_SET, 32'h0000_0301, "R3 set ORs");
    wr(A_CLR, 32'h0000_0101);
    rd(A_CLR, 32'h0000_0200, "R4 clear address reads mask");
    rd(A_SET, 32'h0000_0200, "R4 clear leaves others");

    // R5 / R7 double-governed sources
    wr(A_X, 32'h0000_5600);
    rd(A_X, 32'h0000_5600, "R5 prio X full width");
    pend = 16'h4000;
    expect_irq(0, 0, 0, "R7 mask bit 8 clear blocks source 14");
    pend = 16'h8000;
    expect_irq(1, 12'hB80, 4'd5, "R7 source 15 enabled");
    wr(A_CLR, 32'h0000_0200);
    expect_irq(0, 0, 0, "R7 mask clear disables source 15");
    wr(A_SET, 32'h0000_0100);
    pend = 16'h4000;
    expect_irq(1, 12'hB00, 4'd6, "R7 source 14 enabled");

    // R10 unassigned fields and addresses
    wr(A_X, 32'hFFFF_00FF);
    wr(A_SET, 32'hFFFF_FFFF);
    pend = 16'hC000;
    expect_irq(0, 0, 0, "R10 unassigned X fields");
    wr(A_B, 32'h0000_000F);
    pend = 16'h3F80;
    expect_irq(0, 0, 0, "R10 unassigned B field");
    pend = 0;
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 0, "R10 unmapped read zero");
    rd(A_A, 32'h0000_1234, "R10 unmapped write ignored");

    // R11 read coinciding with write
    wr(A_A, 32'h0000_0777);
    check(rdata == 32'h1234, "R11 pre-write value", rdata, 32'h1234);
    rd(A_A, 32'h0000_0777, "R11 new value next read");

    // R9 every vector
    wr(A_A, 32'h1111);
    wr(A_B, 32'h1110);
    wr(A_X, 32'h1100);
    for (int s = 0; s < 16; s++) begin
      pend = 16'(1) << s;
      expect_irq(1, exp_vec(s), 4'd1, "R9 vector table");
      tick();
    end
    pend = 0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule